// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a four-bank synchronous DRAM from reset until the memory can accept normal traffic. Straight out of reset it drives the clock enable high and places NOP on the command bus. It keeps doing so for a stabilization interval whose length in cycles is the product of a clock-frequency parameter and a wait-time parameter. It then walks the required start-up order: one precharge that closes every bank, a configurable number of auto-refresh commands, and a mode register load. When partial-array self refresh is wanted, a second mode load for the extended register follows. Each command is separated from the next by a parameterized recovery interval.

When the last required command has had its recovery time, the block raises a one-cycle ready pulse and a done level. From then on it drives only NOP, so a memory controller can take over the command bus. All command, bank and address outputs are registered, so the pins change only on clock edges.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, the outputs show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), init_done = 0 and init_ready = 0.
- R2: After reset is released, exactly CLK_MHZ*STABLE_US NOP cycles appear. The next cycle carries PRECHARGE (0010) with address bit 10 high, so that all banks are closed.
- R3: After the precharge, the block issues N = max(2, cfg_refresh_cnt) AUTO REFRESH commands (0001). The first one comes T_RP cycles after the precharge, and each later one comes T_RC cycles after the one before it.
- R4: T_RC cycles after the last refresh, a MODE SET (0000) appears with sd_ba = 00. Its address carries: bits [2:0] the burst length code (cfg_burst_len 0→000 for 1 word, 1→001 for 2, 2→010 for 4, 3→011 for 8, 4..7→111 for full page); bit 3 the burst type (1 = interleaved, 0 = sequential); bits [6:4] the CAS latency (1, 2 or 3, with a request of 0 driven as 3). All other address bits are 0.
- R5: With cfg_pasr_en = 1, a second MODE SET (0000) with sd_ba = 10 comes T_MRD cycles after the first. Its address bits [2:0] carry the array selection (000 full, 001 half, 010 quarter). Any other cfg_pasr_sel value is driven as 000 (full array). All other address bits are 0.
- R6: With cfg_pasr_en = 0, no extended mode set is issued, and the sequence ends after the normal mode set.
- R7: init_ready is high for exactly one cycle, T_MRD cycles after the last mode set. init_done rises in that same cycle and stays high until reset.
- R8: Every command is followed by at least one NOP cycle. Only NOP, PRECHARGE, AUTO REFRESH and MODE SET ever appear on the pins, and after init_done only NOP appears.
- R9: sd_cke is high in every cycle, during reset as well as after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| cfg_burst_len | input | 3 | Burst length select (0:1, 1:2, 2:4, 3:8, 4..7: full page) |
| cfg_burst_ilv | input | 1 | Burst type, 1 = interleaved, 0 = sequential |
| cfg_cas_lat | input | 2 | CAS latency 1..3; 0 is treated as 3 |
| cfg_pasr_en | input | 1 | Request the extended mode set for partial-array refresh |
| cfg_pasr_sel | input | 3 | Array fraction kept in self refresh (0 full, 1 half, 2 quarter) |
| cfg_refresh_cnt | input | RCNT_W | Number of start-up refreshes; values below 2 give 2 |
| sd_cke | output | 1 | Clock enable to the memory, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address; it selects the mode register during mode sets |
| sd_addr | output | ADDR_W | Address bus; it carries the mode words and the all-bank flag |
| init_ready | output | 1 | One-cycle pulse when initialization completes |
| init_done | output | 1 | Level that stays high once initialization is complete |

## Verification
The assertions watch the pins on every cycle. They check that every precharge carries the all-bank flag and that each command is followed by a NOP. They check that mode sets use only bank codes 00 and 10, that only NOP appears after done, and that the ready pulse lasts one cycle. They also check that the refresh budget has been used up before the mode set. Only the bench's scenarios can show the exact cycle positions: the stabilization length, the T_RP, T_RC and T_MRD spacing, and the refresh count with its clamp to 2. The same holds for the address contents of both mode words under the different burst, latency and array selections, and for the presence or absence of the extended mode set.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Pin encoding {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        S_STABLE,
        S_PRE,
        S_GAP,
        S_REF,
        S_MRS,
        S_EMRS,
        S_FIN,
        S_DONE
    } seq_state_e;

    localparam int WORD_W = 12;

    typedef struct packed {
        sdram_cmd_e          cmd;
        logic [1:0]          ba;
        logic [WORD_W-1:0]   word;
    } cmd_req_t;

    localparam logic [1:0] BA_MODE = 2'b00;
    localparam logic [1:0] BA_EXT  = 2'b10;
    localparam logic [WORD_W-1:0] WORD_ALLBANK = 12'h400;

    function automatic logic [2:0] burst_code(input logic [2:0] sel);
        logic [2:0] c;
        case (sel)
            3'd0:    c = 3'b000;
            3'd1:    c = 3'b001;
            3'd2:    c = 3'b010;
            3'd3:    c = 3'b011;
            default: c = 3'b111;
        endcase
        return c;
    endfunction

    function automatic logic [2:0] latency_code(input logic [1:0] lat);
        return (lat == 2'd0) ? 3'd3 : {1'b0, lat};
    endfunction

    function automatic logic [WORD_W-1:0] mode_word(input logic [2:0] bl_sel,
                                                    input logic       ilv,
                                                    input logic [1:0] lat);
        return {5'b0, latency_code(lat), ilv, burst_code(bl_sel)};
    endfunction

    function automatic logic [WORD_W-1:0] ext_word(input logic [2:0] sel);
        logic [2:0] s;
        s = (sel <= 3'd2) ? sel : 3'd0;
        return {9'b0, s};
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int TW      = 16,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= TW'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - TW'(1);
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int TW     = 16,
    parameter int RCNT_W = 4,
    parameter int T_RP   = 3,
    parameter int T_RC   = 7,
    parameter int T_MRD  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_zero,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_ilv,
    input  logic [1:0]        cfg_cas_lat,
    input  logic              cfg_pasr_en,
    input  logic [2:0]        cfg_pasr_sel,
    input  logic [RCNT_W-1:0] cfg_refresh_cnt,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    output cmd_req_t          req,
    output logic              fin
);
    // A gap state lasting (load+1) cycles puts the next command T cycles later.
    localparam logic [TW-1:0] RP_LD  = TW'(T_RP  - 2);
    localparam logic [TW-1:0] RC_LD  = TW'(T_RC  - 2);
    localparam logic [TW-1:0] MRD_LD = TW'(T_MRD - 2);
    localparam logic [RCNT_W-1:0] MIN_REF = RCNT_W'(2);

    seq_state_e        state, state_d, nxt, nxt_d;
    logic [RCNT_W-1:0] left, left_d, eff_cnt;

    assign eff_cnt = (cfg_refresh_cnt < MIN_REF) ? MIN_REF : cfg_refresh_cnt;

    always_comb begin
        state_d  = state;
        nxt_d    = nxt;
        left_d   = left;
        tmr_load = 1'b0;
        tmr_val  = '0;
        fin      = 1'b0;
        req      = '{cmd: CMD_NOP, ba: 2'b00, word: '0};
        case (state)
            S_STABLE: if (tmr_zero) state_d = S_PRE;
            S_PRE: begin
                req      = '{cmd: CMD_PRE, ba: 2'b00, word: WORD_ALLBANK};
                tmr_load = 1'b1;
                tmr_val  = RP_LD;
                left_d   = eff_cnt;
                nxt_d    = S_REF;
                state_d  = S_GAP;
            end
            S_GAP: if (tmr_zero) state_d = nxt;
            S_REF: begin
                req      = '{cmd: CMD_REF, ba: 2'b00, word: '0};
                tmr_load = 1'b1;
                tmr_val  = RC_LD;
                left_d   = left - RCNT_W'(1);
                nxt_d    = (left == RCNT_W'(1)) ? S_MRS : S_REF;
                state_d  = S_GAP;
            end
            S_MRS: begin
                req      = '{cmd: CMD_MRS, ba: BA_MODE,
                             word: mode_word(cfg_burst_len, cfg_burst_ilv, cfg_cas_lat)};
                tmr_load = 1'b1;
                tmr_val  = MRD_LD;
                nxt_d    = cfg_pasr_en ? S_EMRS : S_FIN;
                state_d  = S_GAP;
            end
            S_EMRS: begin
                req      = '{cmd: CMD_MRS, ba: BA_EXT, word: ext_word(cfg_pasr_sel)};
                tmr_load = 1'b1;
                tmr_val  = MRD_LD;
                nxt_d    = S_FIN;
                state_d  = S_GAP;
            end
            S_FIN: begin
                fin     = 1'b1;
                state_d = S_DONE;
            end
            default: state_d = S_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_STABLE;
            nxt   <= S_PRE;
            left  <= '0;
        end else begin
            state <= state_d;
            nxt   <= nxt_d;
            left  <= left_d;
        end
    end

    AST_REF_EXHAUSTED: assert property (@(posedge clk) disable iff (rst)
        (state == S_MRS) |-> (left == '0)); // R3
    AST_FIN_ONCE: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin); // R7

endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_req_t          req,
    input  logic              fin,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [1:0]        sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_ready,
    output logic              init_done
);
    logic [ADDR_W-1:0] addr_d;
    logic [3:0]        pin_cmd;

    generate
        if (ADDR_W > WORD_W) begin : g_pad
            assign addr_d = {{(ADDR_W-WORD_W){1'b0}}, req.word};
        end else if (ADDR_W == WORD_W) begin : g_same
            assign addr_d = req.word;
        end else begin : g_trim
            assign addr_d = req.word[ADDR_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sd_cke     <= 1'b1;
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= CMD_NOP;
            sd_ba      <= 2'b00;
            sd_addr    <= '0;
            init_ready <= 1'b0;
            init_done  <= 1'b0;
        end else begin
            sd_cke     <= 1'b1;
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= req.cmd;
            sd_ba      <= req.ba;
            sd_addr    <= addr_d;
            init_ready <= fin;
            if (fin) init_done <= 1'b1;
        end
    end

    assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    AST_PRE_ALLBANK: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd == CMD_PRE) |-> sd_addr[10]); // R2
    AST_MODE_BANK: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd == CMD_MRS) |-> (sd_ba == BA_MODE || sd_ba == BA_EXT)); // R5
    AST_CMD_KNOWN: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd == CMD_NOP || pin_cmd == CMD_PRE ||
         pin_cmd == CMD_REF || pin_cmd == CMD_MRS)); // R8
    AST_CMD_SPACED: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd != CMD_NOP) |=> (pin_cmd == CMD_NOP)); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (pin_cmd == CMD_NOP)); // R8
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        init_ready |=> !init_ready); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R7
    AST_READY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        init_ready |-> init_done); // R7

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int STABLE_US = 200,
    parameter int T_RP      = 3,
    parameter int T_RC      = 7,
    parameter int T_MRD     = 2,
    parameter int RCNT_W    = 4,
    parameter int ADDR_W    = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_ilv,
    input  logic [1:0]        cfg_cas_lat,
    input  logic              cfg_pasr_en,
    input  logic [2:0]        cfg_pasr_sel,
    input  logic [RCNT_W-1:0] cfg_refresh_cnt,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [1:0]        sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_ready,
    output logic              init_done
);
    localparam int WAIT_CYC = CLK_MHZ * STABLE_US;
    localparam int TW       = $clog2(WAIT_CYC + T_RP + T_RC + T_MRD) + 1;

    logic          tmr_load, tmr_zero, fin;
    logic [TW-1:0] tmr_val;
    cmd_req_t      req;

    sdram_init_timer #(.TW(TW), .RST_VAL(WAIT_CYC - 1)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sdram_init_fsm #(
        .TW(TW), .RCNT_W(RCNT_W), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)
    ) u_fsm (
        .clk             (clk),
        .rst             (rst),
        .tmr_zero        (tmr_zero),
        .cfg_burst_len   (cfg_burst_len),
        .cfg_burst_ilv   (cfg_burst_ilv),
        .cfg_cas_lat     (cfg_cas_lat),
        .cfg_pasr_en     (cfg_pasr_en),
        .cfg_pasr_sel    (cfg_pasr_sel),
        .cfg_refresh_cnt (cfg_refresh_cnt),
        .tmr_load        (tmr_load),
        .tmr_val         (tmr_val),
        .req             (req),
        .fin             (fin)
    );

    sdram_init_pins #(.ADDR_W(ADDR_W)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .fin        (fin),
        .sd_cke     (sd_cke),
        .sd_cs_n    (sd_cs_n),
        .sd_ras_n   (sd_ras_n),
        .sd_cas_n   (sd_cas_n),
        .sd_we_n    (sd_we_n),
        .sd_ba      (sd_ba),
        .sd_addr    (sd_addr),
        .init_ready (init_ready),
        .init_done  (init_done)
    );

endmodule

// File: tb/sdram_pwrup_seq_test.sv
module sdram_pwrup_seq_test;
    localparam int CLK_MHZ = 100, STABLE_US = 2;
    localparam int W = CLK_MHZ * STABLE_US;
    localparam int TRP = 3, TRC = 7, TMRD = 2, RCNT_W = 4, ADDR_W = 13;
    localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

    logic clk = 1'b0, rst = 1'b1;
    logic [2:0] cfg_burst_len = 0;
    logic cfg_burst_ilv = 0;
    logic [1:0] cfg_cas_lat = 0;
    logic cfg_pasr_en = 0;
    logic [2:0] cfg_pasr_sel = 0;
    logic [RCNT_W-1:0] cfg_refresh_cnt = 0;
    logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_ready, init_done;
    logic [1:0] sd_ba;
    logic [ADDR_W-1:0] sd_addr;
    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    sdram_pwrup_seq #(.CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .T_RP(TRP), .T_RC(TRC),
                      .T_MRD(TMRD), .RCNT_W(RCNT_W), .ADDR_W(ADDR_W)) uut (.*);

    function automatic logic [31:0] exp_mode(input logic [2:0] bl, input logic ilv, input logic [1:0] cas);
        int blc, casc;
        blc  = (bl <= 3) ? int'(bl) : 7;
        casc = (cas == 0) ? 3 : int'(cas);
        return 32'((casc << 4) | (int'(ilv) << 3) | blc);
    endfunction

    function automatic logic [31:0] exp_ext(input logic [2:0] ps);
        return (ps <= 2) ? 32'(ps) : 32'd0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic run_case(input logic [2:0] bl, input logic ilv, input logic [1:0] cas,
                            input logic en, input logic [2:0] ps, input logic [RCNT_W-1:0] rc);
        int n, t_pre, t_ref0, t_mrs, t_emrs, t_rdy;
        logic [3:0] ec;
        string tag;
        @(negedge clk);
        rst = 1'b1;
        cfg_burst_len = bl; cfg_burst_ilv = ilv; cfg_cas_lat = cas;
        cfg_pasr_en = en; cfg_pasr_sel = ps; cfg_refresh_cnt = rc;
        repeat (3) @(negedge clk);
        chk("R1", "reset cmd", 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(NOP));
        chk("R1", "reset done/ready", {30'b0, init_done, init_ready}, 32'd0);
        chk("R9", "reset cke", 32'(sd_cke), 32'd1);
        rst = 1'b0;
        n      = (rc < 2) ? 2 : int'(rc);
        t_pre  = W + 1;
        t_ref0 = t_pre + TRP;
        t_mrs  = t_ref0 + n * TRC;
        t_emrs = t_mrs + TMRD;
        t_rdy  = (en ? t_emrs : t_mrs) + TMRD;
        for (int t = 1; t <= t_rdy + 4; t++) begin
            @(negedge clk);
            ec = NOP;
            tag = (t > t_rdy) ? "R8" : (t == 1) ? "R1" : "R2";
            if (t == t_pre) begin
                ec = PRE; tag = "R2";
                chk("R2", "precharge A10", 32'(sd_addr[10]), 32'd1);
            end else if (t >= t_ref0 && t < t_mrs) begin
                tag = "R3";
                if ((t - t_ref0) % TRC == 0) ec = REF;
            end else if (t == t_mrs) begin
                ec = MRS; tag = "R4";
                chk("R4", "mode ba", 32'(sd_ba), 32'd0);
                chk("R4", "mode addr", 32'(sd_addr), exp_mode(bl, ilv, cas));
            end else if (t == t_emrs && en) begin
                ec = MRS; tag = "R5";
                chk("R5", "ext ba", 32'(sd_ba), 32'd2);
                chk("R5", "ext addr", 32'(sd_addr), exp_ext(ps));
            end else if (t == t_emrs && !en) begin
                tag = "R6";
            end
            chk(tag, "cmd", 32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(ec));
            chk("R7", "ready/done", {30'b0, init_ready, init_done},
                {30'b0, (t == t_rdy), (t >= t_rdy)});
            chk("R9", "cke", 32'(sd_cke), 32'd1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5D12_0A77));
        // directed corners
        run_case(3'd0, 1'b0, 2'd2, 1'b0, 3'd0, 4'd0);   // R3 clamp from 0, R6 no ext
        run_case(3'd7, 1'b1, 2'd0, 1'b1, 3'd5, 4'd1);   // R4 full page, CAS 0->3; R5 sel 5->full
        run_case(3'd3, 1'b0, 2'd1, 1'b1, 3'd2, 4'd2);   // R5 quarter
        run_case(3'd4, 1'b1, 2'd3, 1'b1, 3'd1, 4'd15);  // R3 max count, R5 half
        for (int i = 0; i < 8; i++) begin
            run_case(3'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                     3'($urandom), RCNT_W'($urandom % 8));
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule